// File: doc/BRIEF.md
# Local-History Two-Level Branch Predictor

This block forecasts the direction of conditional branches that resist static prediction. Each branch seen by the predictor owns a small record holding the last four resolved outcomes of that branch. This per-branch outcome pattern picks a two-bit saturating counter in one of several pattern tables. The tables are common to all branches, so branches with similar outcome patterns train the same counters.

The fetch side presents a branch address on the predict port and gets a taken or not-taken answer combinationally in the same cycle. The execute side reports each resolved branch on the update port with its address, its actual direction and a compiler hint. When the hint marks the branch as statically easy, the branch never claims a record. Updates take effect at the next rising clock edge.

Top module: `lhist_predictor`

## Requirements
- R1: After reset every history record is empty and every counter holds 1, so every predicted address reads not-taken until an update arrives.
- R2: The record for an address is chosen by address bits [9:4] and tagged with bits [17:10]. A prediction whose record is empty or carries a different tag is not-taken.
- R3: An update that misses and has its easy hint low fills the record at its index with its tag and an all-zero history.
- R4: An update that misses with the easy hint high leaves the records unchanged, so the branch keeps predicting not-taken.
- R5: An update that hits trains the selected counter. It adds one when taken and subtracts one when not-taken, and it stays within 0 to 3. A hitting prediction is taken when its counter is 2 or 3.
- R6: An update that hits shifts the resolved direction into bit 0 of that record's 4-bit history, and the oldest bit falls off.
- R7: Address bits [5:4] pick one of four shared tables of 16 counters, and the record's history picks the counter within that table. Distinct branches with equal bits [5:4] and equal history use the same counter.
- R8: The easy hint only blocks filling a record. A hitting update with the hint high still trains its counter and shifts its history.
- R9: The prediction is a same-cycle function of the stored state. An update applied in the same cycle as a prediction becomes visible only from the next cycle.
- R10: A non-hinted update that misses on an index held by another tag replaces that record, and the evicted branch then predicts not-taken.
- R11: Filling a record on a miss leaves every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| predPc | input | 32 | Address of the branch being predicted |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |
| updEasyHint | input | 1 | Compiler marks the branch as statically easy |

## Verification
The predicted direction is due in the same cycle its address is presented, with no register on the way. An update changes state at the rising edge that samples it, so its effect shows up in the prediction of the following cycle. The bench drives both ports at the falling edge and compares `predTaken` against a behavioural model a short delay later, still before the next rising edge. It applies each update to the model only after that rising edge. This keeps a same-cycle predict and update of one branch compared against the old state, as R9 requires.

// File: rtl/lhist_pkg.sv
package lhist_pkg;
  // Strobes from control to datapath for one update cycle.
  typedef struct packed {
    logic trainCtr;    // adjust the selected pattern counter
    logic ctrUp;       // direction of that adjustment
    logic shiftHist;   // shift the outcome into the record's history
    logic allocEntry;  // claim the record for this branch
  } lhistStrobe_t;
endpackage

// File: rtl/lhist_ctrl.sv
module lhist_ctrl
  import lhist_pkg::*;
(
  input  logic         updValid,
  input  logic         updTaken,
  input  logic         updEasyHint,
  input  logic         updHit,
  output lhistStrobe_t strb
);
  always_comb begin
    strb            = '0;
    strb.ctrUp      = updTaken;
    if (updValid) begin
      if (updHit) begin
        strb.trainCtr  = 1'b1;
        strb.shiftHist = 1'b1;
      end else if (!updEasyHint) begin
        strb.allocEntry = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lhist_datapath.sv
module lhist_datapath
  import lhist_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 4,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 8,
  parameter int HIST_W = 4,
  parameter int SEL_W  = 2,
  parameter int CTR_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] predPc,
  output logic            predHit,
  output logic            predTaken,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  output logic            updHit,
  input  lhistStrobe_t    strb
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TABLES  = 1 << SEL_W;
  localparam int CTRS    = 1 << HIST_W;
  localparam int TAG_LO  = IDX_LO + IDX_W;
  localparam int TAG_HI  = TAG_LO + TAG_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1);

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [HIST_W-1:0]  histQ [ENTRIES];
  logic [CTR_W-1:0]   ctrQ  [TABLES][CTRS];

  // Predict lookup
  logic [IDX_W-1:0]  predIdx;
  logic [TAG_W-1:0]  predTag;
  logic [SEL_W-1:0]  predSel;
  logic [CTR_W-1:0]  predCtr;
  assign predIdx   = predPc[TAG_LO-1:IDX_LO];
  assign predTag   = predPc[TAG_HI-1:TAG_LO];
  assign predSel   = predPc[IDX_LO+SEL_W-1:IDX_LO];
  assign predHit   = validQ[predIdx] && (tagQ[predIdx] == predTag);
  assign predCtr   = ctrQ[predSel][histQ[predIdx]];
  assign predTaken = predHit && predCtr[CTR_W-1];

  // Update lookup
  logic [IDX_W-1:0]  updIdx;
  logic [TAG_W-1:0]  updTag;
  logic [SEL_W-1:0]  updSel;
  logic [HIST_W-1:0] updHist;
  logic [CTR_W-1:0]  updCtr;
  logic [CTR_W-1:0]  ctrNext;
  assign updIdx  = updPc[TAG_LO-1:IDX_LO];
  assign updTag  = updPc[TAG_HI-1:TAG_LO];
  assign updSel  = updPc[IDX_LO+SEL_W-1:IDX_LO];
  assign updHit  = validQ[updIdx] && (tagQ[updIdx] == updTag);
  assign updHist = histQ[updIdx];
  assign updCtr  = ctrQ[updSel][updHist];

  always_comb begin
    ctrNext = updCtr;
    if (strb.ctrUp && updCtr != CTR_MAX)      ctrNext = updCtr + CTR_W'(1);
    else if (!strb.ctrUp && updCtr != '0)     ctrNext = updCtr - CTR_W'(1);
  end

  logic unusedPcBits;
  assign unusedPcBits = ^{predPc[PC_W-1:TAG_HI], predPc[IDX_LO-1:0],
                          updPc[PC_W-1:TAG_HI], updPc[IDX_LO-1:0], updTaken};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tagQ[e]  <= '0;
        histQ[e] <= '0;
      end
      for (int t = 0; t < TABLES; t++)
        for (int c = 0; c < CTRS; c++)
          ctrQ[t][c] <= CTR_INIT;
    end else begin
      if (strb.allocEntry) begin
        validQ[updIdx] <= 1'b1;
        tagQ[updIdx]   <= updTag;
        histQ[updIdx]  <= '0;
      end
      if (strb.shiftHist)
        histQ[updIdx] <= {updHist[HIST_W-2:0], strb.ctrUp};
      if (strb.trainCtr)
        ctrQ[updSel][updHist] <= ctrNext;
    end
  end
endmodule

// File: rtl/lhist_predictor.sv
module lhist_predictor
  import lhist_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 4,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 8,
  parameter int HIST_W = 4,
  parameter int SEL_W  = 2,
  parameter int CTR_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updEasyHint
);
  lhistStrobe_t strb;
  logic         updHit;
  logic         predHit;

  lhist_ctrl u_ctrl (
    .updValid    (updValid),
    .updTaken    (updTaken),
    .updEasyHint (updEasyHint),
    .updHit      (updHit),
    .strb        (strb)
  );

  lhist_datapath #(
    .PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .HIST_W(HIST_W), .SEL_W(SEL_W), .CTR_W(CTR_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .predPc    (predPc),
    .predHit   (predHit),
    .predTaken (predTaken),
    .updPc     (updPc),
    .updTaken  (updTaken),
    .updHit    (updHit),
    .strb      (strb)
  );
endmodule

// File: rtl/lhist_checker.sv
module lhist_checker
  import lhist_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] predPc,
  input logic            predTaken,
  input logic            predHit,
  input logic            updValid,
  input logic            updTaken,
  input logic            updEasyHint,
  input logic            updHit,
  input lhistStrobe_t    strb
);
  // R2
  miss_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !predHit |-> !predTaken);

  // R4
  hint_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.allocEntry |-> (updValid && !updHit && !updEasyHint));

  // R8
  hit_trains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && updHit) |-> (strb.trainCtr && strb.shiftHist && strb.ctrUp == updTaken));

  // R11
  alloc_no_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.allocEntry, strb.trainCtr}));

  // R6
  shift_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shiftHist |-> (updValid && updHit));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updValid |=> ($stable(predPc) -> $stable(predTaken)));
endmodule

bind lhist_predictor lhist_checker #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .predPc      (predPc),
  .predTaken   (predTaken),
  .predHit     (predHit),
  .updValid    (updValid),
  .updTaken    (updTaken),
  .updEasyHint (updEasyHint),
  .updHit      (updHit),
  .strb        (strb)
);

// File: tb/lhist_predictor_tb.sv
module lhist_predictor_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [31:0] predPc, updPc;
  logic        predTaken, updValid, updTaken, updEasyHint;

  int    vecCount  = 0;
  int    missCount = 0;
  string curReq    = "R1";

  // behavioural model
  bit mValid [64];
  int mTag   [64];
  int mHist  [64];
  int mCtr   [4][16];

  lhist_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updEasyHint(updEasyHint)
  );

  function automatic logic [31:0] mkPc(int tag, int idx);
    logic [13:0] hi = 14'($urandom);
    logic [3:0]  lo = 4'($urandom);
    return {hi, 8'(tag), 6'(idx), lo};
  endfunction

  function automatic bit mHitOf(logic [31:0] pc);
    return mValid[pc[9:4]] && mTag[pc[9:4]] == int'(pc[17:10]);
  endfunction

  function automatic bit mPredict(logic [31:0] pc);
    if (!mHitOf(pc)) return 1'b0;
    return mCtr[pc[5:4]][mHist[pc[9:4]]] >= 2;
  endfunction

  function automatic void mUpdate(logic [31:0] pc, bit taken, bit hint);
    int i = int'(pc[9:4]);
    int s = int'(pc[5:4]);
    if (mHitOf(pc)) begin
      if (taken && mCtr[s][mHist[i]] < 3) mCtr[s][mHist[i]]++;
      else if (!taken && mCtr[s][mHist[i]] > 0) mCtr[s][mHist[i]]--;
      mHist[i] = ((mHist[i] << 1) | int'(taken)) & 15;
    end else if (!hint) begin
      mValid[i] = 1'b1;
      mTag[i]   = int'(pc[17:10]);
      mHist[i]  = 0;
    end
  endfunction

  task automatic cyc(logic [31:0] pPc, bit uV, logic [31:0] uPc, bit uT, bit uH);
    bit expTaken;
    @(negedge clk);
    predPc = pPc; updValid = uV; updPc = uPc; updTaken = uT; updEasyHint = uH;
    #2;
    expTaken = mPredict(pPc);
    vecCount++;
    if (predTaken !== expTaken) begin
      missCount++;
      $display("FAIL %s: predTaken=%0b expected=%0b pc=%h", curReq, predTaken, expTaken, pPc);
    end
    @(posedge clk);
    if (uV) mUpdate(uPc, uT, uH);
  endtask

  task automatic predOnly(logic [31:0] pPc);
    cyc(pPc, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    logic [31:0] pcA, pcB, pcC, pcD;
    rst_n = 1'b0; predPc = '0; updValid = 1'b0; updPc = '0; updTaken = 1'b0; updEasyHint = 1'b0;
    for (int i = 0; i < 64; i++) mValid[i] = 1'b0;
    for (int t = 0; t < 4; t++) for (int c = 0; c < 16; c++) mCtr[t][c] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty after reset
    curReq = "R1";
    for (int i = 0; i < 16; i++) predOnly(mkPc($urandom % 256, $urandom % 64));

    // R3 and R11: fill on miss, counters untouched
    curReq = "R3/R11";
    pcA = mkPc(8'h11, 5);
    cyc(pcA, 1'b1, pcA, 1'b1, 1'b0);
    predOnly(pcA);

    // R5 and R6: train toward taken, then back
    curReq = "R5/R6";
    for (int i = 0; i < 12; i++) cyc(pcA, 1'b1, pcA, 1'b1, 1'b0);
    predOnly(pcA);
    for (int i = 0; i < 8; i++) cyc(pcA, 1'b1, pcA, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) cyc(pcA, 1'b1, pcA, (i % 3) != 0, 1'b0);

    // R2: same index, other tag, after training taken
    curReq = "R2";
    for (int i = 0; i < 8; i++) cyc(pcA, 1'b1, pcA, 1'b1, 1'b0);
    predOnly(pcA);
    predOnly(mkPc(8'h22, 5));

    // R9: same-cycle predict and update of one branch
    curReq = "R9";
    for (int i = 0; i < 6; i++) cyc(pcA, 1'b1, pcA, 1'b0, 1'b0);

    // R4: hinted misses stay out
    curReq = "R4";
    pcB = mkPc(8'h33, 9);
    for (int i = 0; i < 4; i++) cyc(pcB, 1'b1, pcB, 1'b1, 1'b1);
    predOnly(pcB);

    // R8: hinted hits still train
    curReq = "R8";
    cyc(pcB, 1'b1, pcB, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) cyc(pcB, 1'b1, pcB, 1'b1, 1'b1);
    predOnly(pcB);

    // R7: new branch on the same table reuses trained counters
    curReq = "R7";
    pcC = mkPc(8'h44, 13);
    cyc(pcC, 1'b1, pcC, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cyc(pcC, 1'b1, pcC, 1'b1, 1'b0);
    predOnly(pcB);

    // R10: eviction by another tag on the same index
    curReq = "R10";
    pcD = mkPc(8'h55, 5);
    cyc(pcA, 1'b1, pcD, 1'b1, 1'b0);
    predOnly(pcA);
    predOnly(pcD);

    // Mixed traffic across R5, R6, R7, R8, R10, R11
    curReq = "R5/R6/R7/R8/R10/R11 mixed";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] p = mkPc(8'h60 + ($urandom % 3), 4 * ($urandom % 4) + ($urandom % 2));
      logic [31:0] u = mkPc(8'h60 + ($urandom % 3), 4 * ($urandom % 4) + ($urandom % 2));
      cyc(p, ($urandom % 4) != 0, u, ($urandom % 3) != 0, ($urandom % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule